// File: doc/BRIEF.md
# Three-Mode Color Palette Register File

This block is the palette store of a bitmap display controller. A host reaches it through four byte-wide ports selected by a two-bit code: an index port and three component ports for green, red and blue. Two mode inputs decide how those ports are read and written. With both low, the ports address four packed digital registers, each holding two 3-bit colors. With the 16-color input high, the index port holds an entry number and the component ports reach a 16-entry table of 4-bit components. With the extended input high, the component ports reach a separate 256-entry table of 8-bit components. The three stores are independent, and each keeps its contents while another mode is active.

A registered change pulse tells the display path that visible palette contents were altered, so it can redraw. On the display side, a pixel index goes in and 8-bit green, red and blue values come out one clock later. The values are decoded in the way the current mode selects.

Top module: `palette_regfile`

## Requirements
- R1: Port codes are 0 index, 1 green, 2 red, 3 blue. In digital mode (both mode inputs low), a write or read on index, green, red or blue reaches digital register 3, 1, 2 or 0 respectively. Reads are combinational on `rd_data`.
- R2: A digital register write raises `pal_changed` for exactly the cycle after the write, and only if the old and new values differ somewhere under mask 0x77.
- R3: In 16-color mode (`mode_a16` high, `mode_ext` low), the index port stores an 8-bit index. Component writes go to entry index[3:0] and store data[3:0]. Component reads return {4'h0, stored}.
- R4: In 16-color mode, a component write raises `pal_changed` only when data[3:0] differs from the stored component.
- R5: In extended mode (`mode_ext` high), component writes store all 8 bits at entry index[7:0], and every component write raises `pal_changed`.
- R6: In either analog mode, an index read returns the stored index, and an index write never raises `pal_changed`.
- R7: After reset, digital registers 0 to 3 hold 0x04, 0x15, 0x26 and 0x37.
- R8: After reset, the 16-color table holds these green/red/blue nibbles for entries 0 to 15: 000, 007, 070, 077, 700, 707, 770, 777, 444, 00F, 0F0, 0FF, F00, F0F, FF0, FFF.
- R9: After reset, entry e of the extended table (base b = e with its low 3 bits cleared, j = e[2:0]) holds gray (b−4, or 0 when b = 0) when j = 0. Otherwise green = j[2]·(b+7), red = j[1]·(b+7) and blue = j[0]·(b+7).
- R10: When both mode inputs are high, extended mode governs reads, writes and lookup.
- R11: Lookup has one cycle of latency. In digital mode, pixel[1:0] picks the register. Pixel[2] = 0 selects bits 6:4 and pixel[2] = 1 selects bits 2:0. In that 3-bit field, bit 2 is green, bit 1 red and bit 0 blue, and each set bit outputs 0xFF and each clear bit 0x00.
- R12: In 16-color mode, lookup uses entry pixel[3:0] and outputs each nibble n as {n,n}. In extended mode, it outputs the stored bytes of entry pixel[7:0].
- R13: The three stores are separate. Writes in one mode leave the other stores and the shared index unchanged, except that an index write in an analog mode updates the index. A digital-mode index-port write leaves the stored index unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_a16 | input | 1 | 16-color analog mode select |
| mode_ext | input | 1 | 256-color extended mode select (wins over mode_a16) |
| wr_en | input | 1 | Host write strobe for the selected port |
| port_sel | input | 2 | Port code: 0 index, 1 green, 2 red, 3 blue |
| wr_data | input | 8 | Host write data |
| rd_data | output | 8 | Host read data for the selected port (combinational) |
| px_idx | input | 8 | Pixel index for display lookup |
| px_g | output | 8 | Looked-up green, one cycle after px_idx |
| px_r | output | 8 | Looked-up red, one cycle after px_idx |
| px_b | output | 8 | Looked-up blue, one cycle after px_idx |
| pal_changed | output | 1 | One-cycle pulse after a visible palette change |

## Verification
The reset contents of all three stores are checked first through host reads and pixel lookups. Sample entries are chosen to separate the gray entries from the bit-selected ones and the first group from the last. Component writes in each mode then use data that is equal under the mode's change mask but unequal overall, and data that truly differs. This tells the masked comparisons apart from plain byte comparisons and from always-pulse behavior. The bench switches modes in both directions with both mode inputs high at one point. This exposes priority faults, stores that alias each other, and digital index-port writes that leak into the shared index.

// File: rtl/palette_pkg.sv
package palette_pkg;

    localparam logic [1:0] PORT_INDEX = 2'd0;
    localparam logic [1:0] PORT_GREEN = 2'd1;
    localparam logic [1:0] PORT_RED   = 2'd2;
    localparam logic [1:0] PORT_BLUE  = 2'd3;

    // component slot order inside a table entry
    localparam int COMP_G = 0;
    localparam int COMP_R = 1;
    localparam int COMP_B = 2;

    typedef enum logic [1:0] {
        PM_DIGITAL = 2'd0,
        PM_ANALOG  = 2'd1,
        PM_EXTEND  = 2'd2
    } pal_mode_e;

    function automatic logic [7:0] dig_init(input int k);
        return 8'((k << 4) | (k + 4));
    endfunction

    function automatic logic [7:0] a16_init(input int ent, input int comp);
        int sel_bit;
        sel_bit = (ent >> (2 - comp)) & 1;
        if (ent == 8) return 8'h04;
        if (sel_bit == 0) return 8'h00;
        return (ent >= 8) ? 8'h0F : 8'h07;
    endfunction

    function automatic logic [7:0] ext_init(input int ent, input int comp);
        int base;
        int j;
        base = ent & ~7;
        j    = ent & 7;
        if (j == 0) return (base == 0) ? 8'h00 : 8'(base - 4);
        if (((j >> (2 - comp)) & 1) == 0) return 8'h00;
        return 8'(base + 7);
    endfunction

    function automatic logic [1:0] comp_of_port(input logic [1:0] p);
        case (p)
            PORT_GREEN: return 2'(COMP_G);
            PORT_RED:   return 2'(COMP_R);
            default:    return 2'(COMP_B);
        endcase
    endfunction

    function automatic logic [1:0] dig_reg_of_port(input logic [1:0] p);
        case (p)
            PORT_INDEX: return 2'd3;
            PORT_GREEN: return 2'd1;
            PORT_RED:   return 2'd2;
            default:    return 2'd0;
        endcase
    endfunction

endpackage

// File: rtl/pal_digital_bank.sv
module pal_digital_bank
    import palette_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [1:0] reg_sel,
    input  logic [7:0] wr_data,
    output logic [7:0] rd_data,
    output logic       wr_differs,
    input  logic [2:0] px,
    output logic [2:0] px_grb
);
    localparam int NREG = 4;
    localparam logic [7:0] VIS_MASK = 8'h77;

    logic [NREG-1:0][7:0] regs_d, regs_q;
    logic [7:0] px_reg;

    always_comb begin
        regs_d = regs_q;
        if (wr_en) regs_d[reg_sel] = wr_data;
        rd_data    = regs_q[reg_sel];
        wr_differs = |((regs_q[reg_sel] ^ wr_data) & VIS_MASK);
        px_reg     = regs_q[px[1:0]];
        px_grb     = px[2] ? px_reg[2:0] : px_reg[6:4];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < NREG; k++) regs_q[k] <= dig_init(k);
        end else begin
            regs_q <= regs_d;
        end
    end

    // R1
    dig_wr_readback_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (reg_sel != $past(reg_sel)) || (rd_data == $past(wr_data)));

    // R13
    dig_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(regs_q));

endmodule

// File: rtl/pal_table_bank.sv
module pal_table_bank
    import palette_pkg::*;
#(
    parameter int ENT_W    = 4,
    parameter int DAT_W    = 4,
    parameter bit EXT_INIT = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [ENT_W-1:0] ent,
    input  logic [1:0]       comp,
    input  logic [DAT_W-1:0] wr_data,
    output logic [DAT_W-1:0] rd_data,
    output logic             wr_differs,
    input  logic [ENT_W-1:0] px_ent,
    output logic [DAT_W-1:0] px_g,
    output logic [DAT_W-1:0] px_r,
    output logic [DAT_W-1:0] px_b
);
    localparam int ENTRIES = 1 << ENT_W;
    localparam int NCOMP   = 3;

    logic [DAT_W-1:0] mem_d    [ENTRIES][NCOMP];
    logic [DAT_W-1:0] mem_q    [ENTRIES][NCOMP];
    logic [DAT_W-1:0] init_val [ENTRIES][NCOMP];

    for (genvar e = 0; e < ENTRIES; e++) begin : g_ent
        for (genvar c = 0; c < NCOMP; c++) begin : g_comp
            if (EXT_INIT) begin : g_ext
                assign init_val[e][c] = DAT_W'(ext_init(e, c));
            end else begin : g_a16
                assign init_val[e][c] = DAT_W'(a16_init(e, c));
            end
        end
    end

    always_comb begin
        mem_d = mem_q;
        if (wr_en) mem_d[ent][comp] = wr_data;
        rd_data    = mem_q[ent][comp];
        wr_differs = (mem_q[ent][comp] != wr_data);
        px_g       = mem_q[px_ent][COMP_G];
        px_r       = mem_q[px_ent][COMP_R];
        px_b       = mem_q[px_ent][COMP_B];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_q <= init_val;
        end else begin
            mem_q <= mem_d;
        end
    end

    // R3 / R5
    tbl_wr_readback_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (ent != $past(ent)) || (comp != $past(comp))
                  || (rd_data == $past(wr_data)));

endmodule

// File: rtl/palette_regfile.sv
module palette_regfile
    import palette_pkg::*;
#(
    parameter int IDX_W = 8,
    parameter int A16_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mode_a16,
    input  logic             mode_ext,
    input  logic             wr_en,
    input  logic [1:0]       port_sel,
    input  logic [7:0]       wr_data,
    output logic [7:0]       rd_data,
    input  logic [IDX_W-1:0] px_idx,
    output logic [7:0]       px_g,
    output logic [7:0]       px_r,
    output logic [7:0]       px_b,
    output logic             pal_changed
);
    localparam int NIB_W = A16_W;
    localparam int REP   = 8 / NIB_W;

    typedef struct packed {
        logic [IDX_W-1:0] idx;
        logic             chg;
        logic [7:0]       g;
        logic [7:0]       r;
        logic [7:0]       b;
    } top_state_t;

    top_state_t st_d, st_q;
    pal_mode_e  mode;
    logic       is_comp, dig_we, a16_we, ext_we, idx_we;
    logic [1:0] comp, dig_sel;

    logic [7:0]       dig_rd;
    logic             dig_diff;
    logic [2:0]       dig_grb;
    logic [NIB_W-1:0] a16_rd, a16_g, a16_r, a16_b;
    logic             a16_diff;
    logic [7:0]       ext_rd, ext_g, ext_r, ext_b;
    logic             ext_diff_unused;

    always_comb begin
        if (mode_ext)      mode = PM_EXTEND;
        else if (mode_a16) mode = PM_ANALOG;
        else               mode = PM_DIGITAL;
        is_comp = (port_sel != PORT_INDEX);
        comp    = comp_of_port(port_sel);
        dig_sel = dig_reg_of_port(port_sel);
        dig_we  = wr_en && (mode == PM_DIGITAL);
        a16_we  = wr_en && (mode == PM_ANALOG) && is_comp;
        ext_we  = wr_en && (mode == PM_EXTEND) && is_comp;
        idx_we  = wr_en && (mode != PM_DIGITAL) && !is_comp;
    end

    pal_digital_bank u_dig (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (dig_we),
        .reg_sel    (dig_sel),
        .wr_data    (wr_data),
        .rd_data    (dig_rd),
        .wr_differs (dig_diff),
        .px         (px_idx[2:0]),
        .px_grb     (dig_grb)
    );

    pal_table_bank #(.ENT_W(A16_W), .DAT_W(NIB_W), .EXT_INIT(1'b0)) u_a16 (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (a16_we),
        .ent        (st_q.idx[A16_W-1:0]),
        .comp       (comp),
        .wr_data    (wr_data[NIB_W-1:0]),
        .rd_data    (a16_rd),
        .wr_differs (a16_diff),
        .px_ent     (px_idx[A16_W-1:0]),
        .px_g       (a16_g),
        .px_r       (a16_r),
        .px_b       (a16_b)
    );

    pal_table_bank #(.ENT_W(IDX_W), .DAT_W(8), .EXT_INIT(1'b1)) u_ext (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (ext_we),
        .ent        (st_q.idx),
        .comp       (comp),
        .wr_data    (wr_data),
        .rd_data    (ext_rd),
        .wr_differs (ext_diff_unused),
        .px_ent     (px_idx),
        .px_g       (ext_g),
        .px_r       (ext_r),
        .px_b       (ext_b)
    );

    always_comb begin
        st_d     = st_q;
        st_d.idx = idx_we ? wr_data[IDX_W-1:0] : st_q.idx;
        st_d.chg = (dig_we && dig_diff) || (a16_we && a16_diff) || ext_we;
        case (mode)
            PM_EXTEND: begin
                st_d.g = ext_g;
                st_d.r = ext_r;
                st_d.b = ext_b;
                rd_data = is_comp ? ext_rd : 8'(st_q.idx);
            end
            PM_ANALOG: begin
                st_d.g = {REP{a16_g}};
                st_d.r = {REP{a16_r}};
                st_d.b = {REP{a16_b}};
                rd_data = is_comp ? 8'(a16_rd) : 8'(st_q.idx);
            end
            default: begin
                st_d.g = {8{dig_grb[2]}};
                st_d.r = {8{dig_grb[1]}};
                st_d.b = {8{dig_grb[0]}};
                rd_data = dig_rd;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign px_g        = st_q.g;
    assign px_r        = st_q.r;
    assign px_b        = st_q.b;
    assign pal_changed = st_q.chg;

    // R2
    chg_needs_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pal_changed |-> $past(wr_en) && ($past(port_sel) != PORT_INDEX || !$past(mode_a16 || mode_ext)));

    // R5
    ext_always_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && mode_ext && port_sel != PORT_INDEX) |=> pal_changed);

    // R6
    idx_write_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (mode_ext || mode_a16) && port_sel == PORT_INDEX) |=> !pal_changed);

    // R13
    idx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && (mode_ext || mode_a16) && port_sel == PORT_INDEX) |=> $stable(st_q.idx));

endmodule

// File: tb/tb_palette_regfile.sv
module tb_palette_regfile;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       mode_a16 = 1'b0, mode_ext = 1'b0, wr_en = 1'b0;
    logic [1:0] port_sel = 2'd0;
    logic [7:0] wr_data = 8'd0, rd_data, px_idx = 8'd0;
    logic [7:0] px_g, px_r, px_b;
    logic       pal_changed;
    int total = 0, bad = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    palette_regfile dut (
        .clk(clk), .rst_n(rst_n), .mode_a16(mode_a16), .mode_ext(mode_ext),
        .wr_en(wr_en), .port_sel(port_sel), .wr_data(wr_data), .rd_data(rd_data),
        .px_idx(px_idx), .px_g(px_g), .px_r(px_r), .px_b(px_b),
        .pal_changed(pal_changed)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    // write and check the change pulse in the following cycle
    task automatic wr(input logic [1:0] sel, input logic [7:0] d, input logic exp_chg, input string req);
        @(negedge clk);
        port_sel = sel; wr_data = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
        chk(req, 8'(pal_changed), 8'(exp_chg));
    endtask

    task automatic rd(input logic [1:0] sel, input logic [7:0] exp, input string req);
        @(negedge clk);
        port_sel = sel;
        #1;
        chk(req, rd_data, exp);
    endtask

    task automatic look(input logic [7:0] px, input logic [7:0] eg, input logic [7:0] er,
                        input logic [7:0] eb, input string req);
        @(negedge clk);
        px_idx = px;
        @(negedge clk);
        chk({req, " g"}, px_g, eg);
        chk({req, " r"}, px_r, er);
        chk({req, " b"}, px_b, eb);
    endtask

    task automatic t_reset_digital();
        chk("R2 reset pulse", 8'(pal_changed), 8'h00);
        rd(2'd0, 8'h37, "R1 R7 index->reg3");
        rd(2'd1, 8'h15, "R1 R7 green->reg1");
        rd(2'd2, 8'h26, "R1 R7 red->reg2");
        rd(2'd3, 8'h04, "R1 R7 blue->reg0");
        look(8'h04, 8'hFF, 8'h00, 8'h00, "R11 px4");
        look(8'h07, 8'hFF, 8'hFF, 8'hFF, "R11 px7");
        look(8'h01, 8'h00, 8'h00, 8'hFF, "R11 px1");
        look(8'h02, 8'h00, 8'hFF, 8'h00, "R11 px2");
    endtask

    task automatic t_analog16();
        @(negedge clk); mode_a16 = 1'b1;
        wr(2'd0, 8'h09, 1'b0, "R6 index write quiet");
        rd(2'd1, 8'h00, "R8 e9 green");
        rd(2'd2, 8'h00, "R8 e9 red");
        rd(2'd3, 8'h0F, "R8 e9 blue");
        look(8'h09, 8'h00, 8'h00, 8'hFF, "R12 R8 e9");
        look(8'h08, 8'h44, 8'h44, 8'h44, "R12 R8 e8");
        look(8'h1A, 8'h00, 8'hFF, 8'h00, "R12 R8 e10 via 1A");
        look(8'h07, 8'h77, 8'h77, 8'h77, "R12 R8 e7");
        wr(2'd0, 8'h23, 1'b0, "R6 index write quiet");
        rd(2'd0, 8'h23, "R6 index read");
        wr(2'd1, 8'h50, 1'b0, "R4 equal low nibble");
        rd(2'd1, 8'h00, "R3 green stored low nibble");
        wr(2'd2, 8'hA7, 1'b0, "R4 equal low nibble");
        rd(2'd2, 8'h07, "R3 red read");
        wr(2'd2, 8'h0C, 1'b1, "R4 differing nibble");
        rd(2'd2, 8'h0C, "R3 red updated");
        look(8'h03, 8'h00, 8'hCC, 8'h77, "R12 e3 after write");
        look(8'h13, 8'h00, 8'hCC, 8'h77, "R3 e3 via 13");
    endtask

    task automatic t_extended();
        @(negedge clk); mode_ext = 1'b1;
        rd(2'd0, 8'h23, "R6 shared index");
        wr(2'd0, 8'h1B, 1'b0, "R6 index write quiet");
        rd(2'd1, 8'h00, "R9 e1B green");
        rd(2'd2, 8'h1F, "R9 R10 e1B red");
        rd(2'd3, 8'h1F, "R9 e1B blue");
        wr(2'd2, 8'h1F, 1'b1, "R5 same value still pulses");
        wr(2'd3, 8'hC3, 1'b1, "R5 write pulses");
        rd(2'd3, 8'hC3, "R5 full byte stored");
        look(8'h1B, 8'h00, 8'h1F, 8'hC3, "R12 e1B");
        look(8'h00, 8'h00, 8'h00, 8'h00, "R9 e00");
        look(8'h08, 8'h04, 8'h04, 8'h04, "R9 e08");
        look(8'hF8, 8'hF4, 8'hF4, 8'hF4, "R9 eF8");
        look(8'hFF, 8'hFF, 8'hFF, 8'hFF, "R9 eFF");
        look(8'h0C, 8'h0F, 8'h00, 8'h00, "R9 e0C");
        look(8'h23, 8'h00, 8'h27, 8'h27, "R9 R10 e23");
    endtask

    task automatic t_back_to_a16();
        @(negedge clk); mode_ext = 1'b0;
        look(8'h1B, 8'h00, 8'hFF, 8'hFF, "R13 a16 e11 untouched");
        look(8'h03, 8'h00, 8'hCC, 8'h77, "R13 a16 e3 untouched");
        rd(2'd2, 8'h0F, "R13 a16 red e11");
    endtask

    task automatic t_digital_writes();
        @(negedge clk); mode_a16 = 1'b0;
        wr(2'd1, 8'h9D, 1'b0, "R2 masked-equal write");
        rd(2'd1, 8'h9D, "R1 green stored");
        wr(2'd1, 8'h25, 1'b1, "R2 visible change");
        look(8'h05, 8'hFF, 8'h00, 8'hFF, "R11 px5");
        look(8'h01, 8'h00, 8'hFF, 8'h00, "R11 px1");
        wr(2'd0, 8'h70, 1'b1, "R1 R2 index port to reg3");
        rd(2'd0, 8'h70, "R1 reg3 read");
        look(8'h03, 8'hFF, 8'hFF, 8'hFF, "R11 px3");
        look(8'h07, 8'h00, 8'h00, 8'h00, "R11 px7");
        @(negedge clk); mode_a16 = 1'b1;
        rd(2'd0, 8'h1B, "R13 index kept");
        look(8'h0B, 8'h00, 8'hFF, 8'hFF, "R13 a16 e11 kept");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset_digital();
        t_analog16();
        t_extended();
        t_back_to_a16();
        t_digital_writes();
        if (!finished) begin
            finished = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule